// File: doc/BRIEF.md
# Smart Card Channel Status and Request Controller

This block holds the status flags of a half-duplex smart card serial channel. From them it drives the interrupt and DMA request lines. A separate character transmitter and receiver report events to it as one-cycle pulses:
- a byte was sent cleanly;
- the card signalled an error on a sent byte;
- a byte arrived, possibly with a parity or framing error.

The CPU writes transmit data, reads and clears the status flags, and sets two enables. The DMA engine serves the transmit and receive requests through acknowledge pulses.

The transmit request follows the transmit-end flag, not a buffer-empty flag. If the card flags a bad character, the block tells the transmitter to resend the held byte. Transmit-end stays low for the whole resend, so the DMA sees exactly one request per byte. The error-signal flag stays set until software clears it. Receive errors raise only the error request.

Top module: `scard_status_top`

## Requirements
- R1: The transmit-end request output `txEndReq` is held at 0 at all times.
- R2: `statusOut` bit layout: bit0 transmit-end, bit1 receive-full, bit2 parity error, bit3 framing/error-signal, bit4 overrun. Out of reset it reads 5'b00001 and all requests are 0. `txReq` is 1 one clock after transmit-end is 1 with `txIe` set, and it drops within one clock of either being removed.
- R3: `rxReq` is 1 one clock after receive-full is 1 with `rxIe` set, and it drops within one clock of either being removed.
- R4: `errReq` is 1 one clock after any of bits 4:2 is 1 with `rxIe` set. `txIe` has no effect on it.
- R5: A `txDmaAck` or `cpuTxWr` pulse clears transmit-end, latches `txDataIn` onto `txByte` and pulses `txLoad` one clock later. A `rxDmaAck` pulse clears receive-full.
- R6: `evTxErrSig` during a transfer sets bit3, pulses `txResend` one clock later with `txByte` unchanged, and keeps transmit-end at 0. Transmit-end returns to 1 only on `evTxDone`.
- R7: Bit3 is not cleared by a resend or by the clean completion that follows it. Only a software clear removes it.
- R8: A received byte with a parity or framing error sets bit2 or bit3 and leaves receive-full and `rxData` unchanged.
- R9: A clean received byte with receive-full already 1 sets bit4 and leaves `rxData` at its old value. Otherwise it loads `rxData` and sets receive-full.
- R10: Software clears a flag by pulsing `stRdEn` while the flag reads 1 and then pulsing `stWrEn` with that bit 0. A write with no arming read clears nothing.
- R11: A hardware set of a flag in the same cycle as its software clear leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txIe | input | 1 | Transmit request enable |
| rxIe | input | 1 | Receive and error request enable |
| cpuTxWr | input | 1 | CPU write of transmit data |
| txDmaAck | input | 1 | DMA service of the transmit request, with data |
| txDataIn | input | DATA_W | Transmit byte for a write or DMA service |
| rxDmaAck | input | 1 | DMA service of the receive request |
| evTxDone | input | 1 | Transmitter finished a byte with no error signal |
| evTxErrSig | input | 1 | Card signalled an error on the sent byte |
| evRxByte | input | 1 | Receiver completed a byte |
| evRxParity | input | 1 | Completed byte had a parity error |
| evRxFrame | input | 1 | Completed byte had a framing error |
| rxByteIn | input | DATA_W | Received byte |
| stRdEn | input | 1 | Status read strobe (arms flags reading 1) |
| stWrEn | input | 1 | Status write strobe |
| stWrData | input | 5 | Status write data; 0 clears an armed flag |
| statusOut | output | 5 | Status flags |
| rxData | output | DATA_W | Received data register |
| txByte | output | DATA_W | Held transmit byte |
| txLoad | output | 1 | Start sending `txByte` |
| txResend | output | 1 | Resend `txByte` after an error signal |
| txReq | output | 1 | Transmit-data-empty request |
| rxReq | output | 1 | Receive-data-full request |
| errReq | output | 1 | Transmit/receive error request |
| txEndReq | output | 1 | Transmit-end request, unused in this mode |

## Verification
Transmit is tried three ways: a clean byte, a byte that draws an error signal and then completes, and both enables toggled. These show whether the request follows transmit-end or the held byte, and whether a resend leaks a second DMA request. Receive is fed four kinds of byte: a clean one into an empty register, a clean one into a full register, one with a parity error and one with a framing error. These separate the capture, overrun and error paths and show whether the data register or receive-full is disturbed. Flag clears are tried with and without an arming read and against a same-cycle hardware set, which tells the read-then-write rule apart from a plain write-zero clear.

// File: rtl/scard_status_pkg.sv
package scard_status_pkg;
  localparam int FLAG_N = 5;
  localparam int F_TEND = 0;
  localparam int F_RDF  = 1;
  localparam int F_PER  = 2;
  localparam int F_ERS  = 3;
  localparam int F_ORER = 4;

  typedef struct packed {
    logic loadTx;
    logic setTend;
    logic setErs;
    logic captureRx;
    logic setRdf;
    logic setPer;
    logic setOrer;
    logic clrRdfDma;
  } strobe_t;

  typedef enum logic {TX_IDLE = 1'b0, TX_BUSY = 1'b1} tx_state_e;
endpackage

// File: rtl/scard_status_ctrl.sv
module scard_status_ctrl
  import scard_status_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cpuTxWr,
  input  logic    txDmaAck,
  input  logic    rxDmaAck,
  input  logic    evTxDone,
  input  logic    evTxErrSig,
  input  logic    evRxByte,
  input  logic    evRxParity,
  input  logic    evRxFrame,
  input  logic    rdfNow,
  output strobe_t stb,
  output logic    txLoad,
  output logic    txResend
);
  tx_state_e txState, txStateNext;
  logic      rxBad;

  assign rxBad = evRxParity | evRxFrame;

  always_comb begin
    stb         = '0;
    txStateNext = txState;
    stb.loadTx  = cpuTxWr | txDmaAck;
    if (txState == TX_BUSY) begin
      if (evTxErrSig) begin
        stb.setErs = 1'b1;
      end else if (evTxDone && !stb.loadTx) begin
        stb.setTend = 1'b1;
        txStateNext = TX_IDLE;
      end
    end
    if (stb.loadTx) txStateNext = TX_BUSY;

    if (evRxByte) begin
      if (evRxParity) stb.setPer = 1'b1;
      if (evRxFrame)  stb.setErs = 1'b1;
      if (!rxBad) begin
        if (rdfNow) begin
          stb.setOrer = 1'b1;
        end else begin
          stb.captureRx = 1'b1;
          stb.setRdf    = 1'b1;
        end
      end
    end
    stb.clrRdfDma = rxDmaAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState  <= TX_IDLE;
      txLoad   <= 1'b0;
      txResend <= 1'b0;
    end else begin
      txState  <= txStateNext;
      txLoad   <= stb.loadTx;
      txResend <= (txState == TX_BUSY) && evTxErrSig && !stb.loadTx;
    end
  end
endmodule

// File: rtl/scard_status_dp.sv
module scard_status_dp
  import scard_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              txIe,
  input  logic              rxIe,
  input  logic [DATA_W-1:0] txDataIn,
  input  logic [DATA_W-1:0] rxByteIn,
  input  logic              stRdEn,
  input  logic              stWrEn,
  input  logic [FLAG_N-1:0] stWrData,
  output logic [FLAG_N-1:0] flags,
  output logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] txByte,
  output logic              txReq,
  output logic              rxReq,
  output logic              errReq
);
  logic [FLAG_N-1:0] armed;
  logic [FLAG_N-1:0] swClr;
  logic [FLAG_N-1:0] hwSet;
  logic [FLAG_N-1:0] hwClr;
  logic [FLAG_N-1:0] flagsNext;

  assign swClr = stWrEn ? (armed & ~stWrData) : '0;

  always_comb begin
    hwSet         = '0;
    hwClr         = '0;
    hwSet[F_TEND] = stb.setTend;
    hwSet[F_RDF]  = stb.setRdf;
    hwSet[F_PER]  = stb.setPer;
    hwSet[F_ERS]  = stb.setErs;
    hwSet[F_ORER] = stb.setOrer;
    hwClr[F_TEND] = stb.loadTx;
    hwClr[F_RDF]  = stb.clrRdfDma;
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    assign flagsNext[i] = hwSet[i] ? 1'b1
                        : ((hwClr[i] | swClr[i]) ? 1'b0 : flags[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags  <= FLAG_N'(1) << F_TEND;
      armed  <= '0;
      rxData <= '0;
      txByte <= '0;
      txReq  <= 1'b0;
      rxReq  <= 1'b0;
      errReq <= 1'b0;
    end else begin
      flags <= flagsNext;
      if (stRdEn)      armed <= flags;
      else if (stWrEn) armed <= '0;
      if (stb.captureRx) rxData <= rxByteIn;
      if (stb.loadTx)    txByte <= txDataIn;
      txReq  <= flags[F_TEND] & txIe;
      rxReq  <= flags[F_RDF] & rxIe;
      errReq <= (flags[F_PER] | flags[F_ERS] | flags[F_ORER]) & rxIe;
    end
  end
endmodule

// File: rtl/scard_status_top.sv
module scard_status_top
  import scard_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txIe,
  input  logic              rxIe,
  input  logic              cpuTxWr,
  input  logic              txDmaAck,
  input  logic [DATA_W-1:0] txDataIn,
  input  logic              rxDmaAck,
  input  logic              evTxDone,
  input  logic              evTxErrSig,
  input  logic              evRxByte,
  input  logic              evRxParity,
  input  logic              evRxFrame,
  input  logic [DATA_W-1:0] rxByteIn,
  input  logic              stRdEn,
  input  logic              stWrEn,
  input  logic [4:0]        stWrData,
  output logic [4:0]        statusOut,
  output logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] txByte,
  output logic              txLoad,
  output logic              txResend,
  output logic              txReq,
  output logic              rxReq,
  output logic              errReq,
  output logic              txEndReq
);
  strobe_t stb;

  scard_status_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuTxWr(cpuTxWr), .txDmaAck(txDmaAck),
    .rxDmaAck(rxDmaAck), .evTxDone(evTxDone), .evTxErrSig(evTxErrSig),
    .evRxByte(evRxByte), .evRxParity(evRxParity), .evRxFrame(evRxFrame),
    .rdfNow(statusOut[F_RDF]), .stb(stb), .txLoad(txLoad), .txResend(txResend)
  );

  scard_status_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txIe(txIe), .rxIe(rxIe),
    .txDataIn(txDataIn), .rxByteIn(rxByteIn), .stRdEn(stRdEn),
    .stWrEn(stWrEn), .stWrData(stWrData), .flags(statusOut),
    .rxData(rxData), .txByte(txByte), .txReq(txReq), .rxReq(rxReq),
    .errReq(errReq)
  );

  assign txEndReq = 1'b0;
endmodule

// File: rtl/scard_status_chk.sv
module scard_status_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              txIe,
  input logic              rxIe,
  input logic              evRxByte,
  input logic              evRxParity,
  input logic              evRxFrame,
  input logic [4:0]        statusOut,
  input logic [DATA_W-1:0] rxData,
  input logic [DATA_W-1:0] txByte,
  input logic              txResend,
  input logic              txReq,
  input logic              rxReq,
  input logic              errReq,
  input logic              txEndReq
);
  p_no_txend_r1: assert property (@(posedge clk) disable iff (!rstN) !txEndReq);
  p_txreq_on_r2: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[0] && txIe) |=> txReq);
  p_txreq_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!statusOut[0] || !txIe) |=> !txReq);
  p_rxreq_on_r3: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[1] && rxIe) |=> rxReq);
  p_rxreq_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!statusOut[1] || !rxIe) |=> !rxReq);
  p_errreq_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((|statusOut[4:2]) && rxIe) |=> errReq);
  p_errgate_r4: assert property (@(posedge clk) disable iff (!rstN)
    !rxIe |=> !errReq);
  p_resend_r6: assert property (@(posedge clk) disable iff (!rstN)
    txResend |-> (!statusOut[0] && statusOut[3] && $stable(txByte)));
  p_rxerr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (evRxByte && (evRxParity || evRxFrame)) |=> ($stable(statusOut[1]) && $stable(rxData)));
endmodule

bind scard_status_top scard_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .txIe(txIe), .rxIe(rxIe), .evRxByte(evRxByte),
  .evRxParity(evRxParity), .evRxFrame(evRxFrame), .statusOut(statusOut),
  .rxData(rxData), .txByte(txByte), .txResend(txResend), .txReq(txReq),
  .rxReq(rxReq), .errReq(errReq), .txEndReq(txEndReq)
);

// File: tb/tb_scard_status_top.sv
`timescale 1ns/1ps
module tb_scard_status_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txIe = 0, rxIe = 0, cpuTxWr = 0, txDmaAck = 0, rxDmaAck = 0;
  logic evTxDone = 0, evTxErrSig = 0, evRxByte = 0, evRxParity = 0, evRxFrame = 0;
  logic stRdEn = 0, stWrEn = 0;
  logic [7:0] txDataIn = 0, rxByteIn = 0;
  logic [4:0] stWrData = 0;
  logic [4:0] statusOut;
  logic [7:0] rxData, txByte;
  logic txLoad, txResend, txReq, rxReq, errReq, txEndReq;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  scard_status_top dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic t_reset();
    chk("R2 reset status", statusOut, 5'b00001);
    chk("R2 reset reqs", {txReq, rxReq, errReq, txLoad, txResend}, 0);
    chk("R1 txEndReq", txEndReq, 0);
  endtask

  task automatic t_txreq();
    txIe = 1; cyc();
    chk("R2 txReq on", txReq, 1);
    txIe = 0; cyc();
    chk("R2 txReq off", txReq, 0);
    txIe = 1; cyc();
  endtask

  task automatic t_tx_dma_resend();
    txDataIn = 8'hA5; txDmaAck = 1; cyc(); txDmaAck = 0; txDataIn = 8'h00;
    chk("R5 tend cleared", statusOut[0], 0);
    chk("R5 txLoad", txLoad, 1);
    chk("R5 txByte", txByte, 8'hA5);
    cyc();
    chk("R5 txReq dropped", txReq, 0);
    evTxErrSig = 1; cyc(); evTxErrSig = 0;
    chk("R6 ers set", statusOut[3], 1);
    chk("R6 txResend", txResend, 1);
    chk("R6 held byte", txByte, 8'hA5);
    cyc();
    chk("R6 tend low", statusOut[0], 0);
    chk("R6 no txReq", txReq, 0);
    chk("R4 txIe no errReq", errReq, 0);
    evTxDone = 1; cyc(); evTxDone = 0;
    chk("R6 tend back", statusOut[0], 1);
    chk("R7 ers kept", statusOut[3], 1);
    rxIe = 1; cyc();
    chk("R4 errReq", errReq, 1);
  endtask

  task automatic t_swclear();
    stWrEn = 1; stWrData = 5'b00000; cyc(); stWrEn = 0;
    chk("R10 no arm no clear", statusOut[3], 1);
    stRdEn = 1; cyc(); stRdEn = 0;
    stWrEn = 1; stWrData = 5'b10111; cyc(); stWrEn = 0;
    chk("R7 ers sw clear", statusOut, 5'b00001);
    cyc();
    chk("R4 errReq off", errReq, 0);
  endtask

  task automatic rxb(input logic [7:0] d, input logic p, input logic f);
    rxByteIn = d; evRxParity = p; evRxFrame = f; evRxByte = 1; cyc();
    evRxByte = 0; evRxParity = 0; evRxFrame = 0;
  endtask

  task automatic t_rx();
    rxb(8'h3C, 0, 0);
    chk("R9 capture", {statusOut[1], rxData}, {1'b1, 8'h3C});
    cyc();
    chk("R3 rxReq", rxReq, 1);
    rxIe = 0; cyc();
    chk("R3 rxReq gated", rxReq, 0);
    rxIe = 1;
    rxb(8'h55, 0, 0);
    chk("R9 overrun", statusOut[4], 1);
    chk("R9 data kept", rxData, 8'h3C);
    rxDmaAck = 1; cyc(); rxDmaAck = 0;
    chk("R5 rdf cleared", statusOut[1], 0);
    rxb(8'h99, 1, 0);
    chk("R8 parity", statusOut[2:1], 2'b10);
    chk("R8 data kept", rxData, 8'h3C);
    rxb(8'h77, 0, 1);
    chk("R8 frame", statusOut[3:1], 3'b110);
    cyc();
    chk("R8 no rxReq", {rxReq, errReq}, 2'b01);
  endtask

  task automatic t_collide();
    stRdEn = 1; cyc(); stRdEn = 0;
    stWrEn = 1; stWrData = 5'b00000;
    rxByteIn = 8'h01; evRxParity = 1; evRxByte = 1; cyc();
    stWrEn = 0; evRxByte = 0; evRxParity = 0;
    chk("R11 set wins", statusOut[2], 1);
    chk("R10 others cleared", {statusOut[4], statusOut[3]}, 2'b00);
  endtask

  initial begin
    fork
      begin
        repeat (3) cyc();
        rstN = 1; cyc();
        t_reset();
        t_txreq();
        t_tx_dma_resend();
        t_swclear();
        t_rx();
        t_collide();
      end
      begin
        repeat (5000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule